// File: doc/BRIEF.md
# Multi-format serial audio transmitter

This block serializes 24-bit audio samples onto a single data line, together with a bit clock and a frame clock. One shared engine handles six frame layouts: plain mono, mono with a one-bit delay, two-channel PCM, I2S, and TDM with or without the one-bit delay. TDM carries from one to eight channels. Every channel occupies a 32-bit slot. The slot holds the 24 sample bits, most significant bit first, followed by eight zero bits.

In master mode the block divides the system clock to make the bit clock, and it generates the frame clock from its own bit counter. In slave mode it synchronizes an external bit clock and frame clock, shifts on the falling edge of the external bit clock, and realigns its frame position whenever it sees the frame marker. Four independent polarity controls invert the two clocks separately for each mode. Samples come from an external FIFO through a one-cycle request: at the start of every slot the block fetches the sample for the following slot. If no sample is offered, the block sends a zero slot and flags an underrun. With rates between 8 kHz and 96 kHz, the divider sets the frame rate as f_sys / (2·(clkDiv+1)·32·channels). Software that plays 16-bit audio places it in the upper 16 bits of the 24-bit sample.

Top module: `audio_tx_serializer`

## Requirements
- R1: `fmtCode` selects the layout: 0 mono, 1 mono delayed, 2 PCM, 3 I2S, 4 TDM, 5 TDM delayed. Codes 6 and 7 are reserved. With a reserved code the block stays idle even when enabled: no requests, data low, clocks static.
- R2: A frame holds 1 channel for codes 0 and 1, 2 channels for codes 2 and 3, and `tdmChans`+1 channels for codes 4 and 5. A frame lasts 32 bit clocks per channel.
- R3: Each slot is 32 bit clocks long. It carries the 24 sample bits MSB first, then 8 zero bits. Data changes only on the falling edge of the (non-inverted) bit clock, so it is stable at the rising edge.
- R4: Codes 1, 3 and 5 put the first slot's MSB one bit clock after the frame-marker bit. Codes 0, 2 and 4 put it in the same bit as the marker.
- R5: The frame clock, before inversion, is low for the first 32 bits of an I2S frame and high for the second 32. For all other codes it is a one-bit-clock high pulse on the first bit of the frame.
- R6: With `masterMode`=1 the bit clock period is 2·(`clkDiv`+1) system clocks. Before inversion the bit clock rests high while idle, so the first edge after enabling is a falling edge that starts bit 0.
- R7: With `masterMode`=0 the block shifts on falling edges of `extBclk`. It takes the frame start from `extLrclk`: a rising edge for pulse formats, a falling edge for I2S. It drives `bclkOut` and `lrclkOut` low.
- R8: `clkInv` bits act independently. Bit 3 inverts the master frame clock output, bit 2 the master bit clock output, bit 1 the slave frame clock input, and bit 0 the slave bit clock input.
- R9: `sampleReq` is a one-cycle pulse at the start of every slot. `sampleData` is taken in that cycle for the next slot. The first slot after enabling is all zeros.
- R10: If `sampleValid` is low during a request, the next slot is all zeros and `underrun` pulses for one cycle, in the cycle after the request. `underrun` never pulses otherwise.
- R11: While `enable` is low, `sdata` is held low, no request is issued and the clock outputs stay static. Re-enabling starts a new frame at bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run the serializer |
| masterMode | input | 1 | 1 = generate clocks, 0 = follow external clocks |
| fmtCode | input | 3 | Frame layout code |
| tdmChans | input | 3 | TDM channel count minus one |
| clkInv | input | 4 | Clock polarity inversion controls |
| clkDiv | input | 8 | Master bit clock half period minus one, in system clocks |
| extBclk | input | 1 | External bit clock (slave) |
| extLrclk | input | 1 | External frame clock (slave) |
| sampleData | input | 24 | Sample offered by the FIFO |
| sampleValid | input | 1 | FIFO has a sample |
| sampleReq | output | 1 | Sample fetch pulse |
| underrun | output | 1 | Pulse: a request found no sample |
| bclkOut | output | 1 | Generated bit clock |
| lrclkOut | output | 1 | Generated frame clock |
| sdata | output | 1 | Serial data |

## Verification
On every cycle the assertions check these rules: serial data moves only on a master falling bit-clock edge, requests are single-cycle and never occur while disabled or with a reserved code, underrun pulses exactly when a request is starved, and data stays low while disabled. Only the bench scenarios can show that the correct bits appear in the correct slot for each layout and delay, that the frame clock has the right shape, that the divider gives the right period, and that slave mode with inverted inputs lines up with an externally driven frame.

// File: rtl/audio_tx_pkg.sv
package audio_tx_pkg;

  typedef enum logic [2:0] {
    FMT_MONO     = 3'd0,
    FMT_MONO_DLY = 3'd1,
    FMT_PCM      = 3'd2,
    FMT_I2S      = 3'd3,
    FMT_TDM      = 3'd4,
    FMT_TDM_DLY  = 3'd5
  } txFmt_e;

  // control -> datapath strobes
  typedef struct packed {
    logic advance;   // move to next bit position
    logic loadSlot;  // new slot begins at this advance
    logic clear;     // block idle
  } txStrobe_t;

endpackage

// File: rtl/audio_tx_ctrl.sv
module audio_tx_ctrl
  import audio_tx_pkg::*;
#(
  parameter int SLOT_BITS = 32,
  parameter int MAX_CH    = 8,
  parameter int DIV_W     = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         enable,
  input  logic                         masterMode,
  input  logic [2:0]                   fmtCode,
  input  logic [$clog2(MAX_CH)-1:0]    tdmChans,
  input  logic [3:0]                   clkInv,
  input  logic [DIV_W-1:0]             clkDiv,
  input  logic                         extBclk,
  input  logic                         extLrclk,
  output logic                         bclkOut,
  output logic                         lrclkOut,
  output txStrobe_t                    strobe
);

  localparam int SLOT_LOG = $clog2(SLOT_BITS);
  localparam int CH_W     = $clog2(MAX_CH);
  localparam int POS_W    = SLOT_LOG + CH_W;

  logic legal, running, isI2s, delayed;
  logic [CH_W-1:0]  chMinus1;
  logic [POS_W-1:0] frameLast, pos, pNext, qNext;

  assign legal   = (fmtCode <= 3'd5);
  assign running = enable & legal;
  assign isI2s   = (fmtCode == FMT_I2S);
  assign delayed = (fmtCode == FMT_MONO_DLY) || (fmtCode == FMT_I2S) || (fmtCode == FMT_TDM_DLY);

  always_comb begin
    case (fmtCode)
      FMT_MONO, FMT_MONO_DLY: chMinus1 = '0;
      FMT_PCM, FMT_I2S:       chMinus1 = CH_W'(1);
      default:                chMinus1 = tdmChans;
    endcase
  end
  assign frameLast = {chMinus1, {SLOT_LOG{1'b1}}};

  // master bit clock divider
  logic [DIV_W-1:0] divCnt;
  logic bclkInt, lrInt, divHit;
  assign divHit = running && masterMode && (divCnt == clkDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      bclkInt <= 1'b1;
    end else if (!running || !masterMode) begin
      divCnt  <= '0;
      bclkInt <= 1'b1;
    end else if (divHit) begin
      divCnt  <= '0;
      bclkInt <= ~bclkInt;
    end else begin
      divCnt  <= divCnt + 1'b1;
    end
  end

  // slave clock synchronizers
  logic [2:0] bSync, lSync;
  logic bNow, bOld, lNow, slvFall, slvRise, markSeen, lrPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bSync <= '0;
      lSync <= '0;
    end else begin
      bSync <= {bSync[1:0], extBclk};
      lSync <= {lSync[1:0], extLrclk};
    end
  end

  assign bNow    = bSync[1] ^ clkInv[0];
  assign bOld    = bSync[2] ^ clkInv[0];
  assign lNow    = lSync[1] ^ clkInv[1];
  assign slvFall = bOld & ~bNow;
  assign slvRise = ~bOld & bNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      markSeen <= 1'b0;
      lrPrev   <= 1'b0;
    end else if (!running || masterMode) begin
      markSeen <= 1'b0;
      lrPrev   <= isI2s;
    end else if (slvRise) begin
      lrPrev <= lNow;
      if (isI2s ? (lrPrev & ~lNow) : (~lrPrev & lNow)) markSeen <= 1'b1;
    end else if (slvFall) begin
      markSeen <= 1'b0;
    end
  end

  // frame position
  logic advance;
  assign advance = running && (masterMode ? (divHit && bclkInt) : slvFall);

  always_comb begin
    if (!masterMode && markSeen)  pNext = POS_W'(1);
    else if (pos >= frameLast)    pNext = '0;
    else                          pNext = pos + 1'b1;
    if (!delayed)                 qNext = pNext;
    else if (pNext == '0)         qNext = frameLast;
    else                          qNext = pNext - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos   <= '1;
      lrInt <= 1'b0;
    end else if (!running) begin
      pos   <= frameLast;
      lrInt <= 1'b0;
    end else if (advance) begin
      pos   <= pNext;
      lrInt <= isI2s ? (pNext >= POS_W'(SLOT_BITS)) : (pNext == '0);
    end
  end

  assign bclkOut  = masterMode ? (bclkInt ^ clkInv[2]) : 1'b0;
  assign lrclkOut = masterMode ? (lrInt ^ clkInv[3]) : 1'b0;

  assign strobe.advance  = advance;
  assign strobe.loadSlot = advance && (qNext[SLOT_LOG-1:0] == '0);
  assign strobe.clear    = !running;

endmodule

// File: rtl/audio_tx_datapath.sv
module audio_tx_datapath
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  txStrobe_t           strobe,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                sampleValid,
  output logic                sampleReq,
  output logic                underrun,
  output logic                sdata
);

  localparam int PAD = SLOT_BITS - SAMPLE_W;

  logic [SAMPLE_W-1:0]  holdReg;
  logic [SLOT_BITS-1:0] shReg;

  assign sampleReq = strobe.loadSlot;
  assign sdata     = shReg[SLOT_BITS-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdReg  <= '0;
      shReg    <= '0;
      underrun <= 1'b0;
    end else begin
      underrun <= sampleReq & ~sampleValid;
      if (strobe.clear) begin
        holdReg <= '0;
        shReg   <= '0;
      end else if (strobe.loadSlot) begin
        shReg   <= {holdReg, {PAD{1'b0}}};
        holdReg <= sampleValid ? sampleData : '0;
      end else if (strobe.advance) begin
        shReg <= shReg << 1;
      end
    end
  end

endmodule

// File: rtl/audio_tx_serializer.sv
module audio_tx_serializer
  import audio_tx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SLOT_BITS = 32,
  parameter int MAX_CH    = 8,
  parameter int DIV_W     = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        enable,
  input  logic                        masterMode,
  input  logic [2:0]                  fmtCode,
  input  logic [$clog2(MAX_CH)-1:0]   tdmChans,
  input  logic [3:0]                  clkInv,
  input  logic [DIV_W-1:0]            clkDiv,
  input  logic                        extBclk,
  input  logic                        extLrclk,
  input  logic [SAMPLE_W-1:0]         sampleData,
  input  logic                        sampleValid,
  output logic                        sampleReq,
  output logic                        underrun,
  output logic                        bclkOut,
  output logic                        lrclkOut,
  output logic                        sdata
);

  txStrobe_t strobe;

  audio_tx_ctrl #(.SLOT_BITS(SLOT_BITS), .MAX_CH(MAX_CH), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .masterMode(masterMode),
    .fmtCode(fmtCode), .tdmChans(tdmChans), .clkInv(clkInv), .clkDiv(clkDiv),
    .extBclk(extBclk), .extLrclk(extLrclk),
    .bclkOut(bclkOut), .lrclkOut(lrclkOut), .strobe(strobe)
  );

  audio_tx_datapath #(.SAMPLE_W(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .sampleData(sampleData), .sampleValid(sampleValid),
    .sampleReq(sampleReq), .underrun(underrun), .sdata(sdata)
  );

endmodule

// File: rtl/audio_tx_serializer_chk.sv
module audio_tx_serializer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       enable,
  input logic       masterMode,
  input logic [2:0] fmtCode,
  input logic       bclkInv,
  input logic       sampleValid,
  input logic       sampleReq,
  input logic       underrun,
  input logic       bclkOut,
  input logic       sdata
);

  // R1
  reserved_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fmtCode >= 3'd6) |-> !sampleReq);

  // R3
  data_on_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable) && masterMode && $past(masterMode) && $stable(bclkInv)
     && $stable(fmtCode) && (sdata != $past(sdata)))
    |-> (!(bclkOut ^ bclkInv) && $past(bclkOut ^ bclkInv)));

  // R9
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleReq |=> !sampleReq);

  // R10
  underrun_raise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleReq && !sampleValid) |=> underrun);

  // R10
  underrun_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> $past(sampleReq && !sampleValid));

  // R11
  idle_no_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> !sampleReq);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && $past(!enable)) |-> (sdata == 1'b0));

endmodule

bind audio_tx_serializer audio_tx_serializer_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .masterMode(masterMode),
  .fmtCode(fmtCode), .bclkInv(clkInv[2]), .sampleValid(sampleValid),
  .sampleReq(sampleReq), .underrun(underrun), .bclkOut(bclkOut), .sdata(sdata)
);

// File: tb/audio_tx_serializer_tb.sv
module audio_tx_serializer_tb;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, enable, masterMode, extBclk, extLrclk, sampleValid;
  logic [2:0] fmtCode, tdmChans;
  logic [3:0] clkInv;
  logic [7:0] clkDiv;
  logic [23:0] sampleData;
  logic sampleReq, underrun, bclkOut, lrclkOut, sdata;

  audio_tx_serializer u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .masterMode(masterMode),
    .fmtCode(fmtCode), .tdmChans(tdmChans), .clkInv(clkInv), .clkDiv(clkDiv),
    .extBclk(extBclk), .extLrclk(extLrclk), .sampleData(sampleData),
    .sampleValid(sampleValid), .sampleReq(sampleReq), .underrun(underrun),
    .bclkOut(bclkOut), .lrclkOut(lrclkOut), .sdata(sdata)
  );

  int nChecks = 0, nFails = 0;
  logic [31:0] expQ[$];
  int srcIdx = 0;
  bit takePending = 0, urExp = 0, armed = 0, done = 0;
  bit monMaster = 1, isI2s = 0, prevB = 1, extLogical = 1;
  int monK = 0, frameLen = 32, dly = 0, cyc = 0, lastRise = 0;
  logic [31:0] word = '0;
  string curTag = "";

  function automatic logic [23:0] sampVal(int i);
    return 24'(i * 32'h0003A1F7 + 32'h0005A5A5);
  endfunction
  assign sampleData = sampVal(srcIdx);

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) cyc++;

  // driver: scoreboard producer, pushes the expected slot for each request
  always @(negedge clk) begin
    if (takePending) begin srcIdx++; takePending = 0; end
    if (urExp) begin
      check(underrun === 1'b1, "R10 underrun after starved request", 32'(underrun), 1);
      urExp = 0;
    end else if (underrun === 1'b1) begin
      check(0, "R10 spurious underrun", 1, 0);
    end
    if (sampleReq === 1'b1) begin
      if (!armed) check(0, "R1 R11 request while idle", 1, 0);
      else begin
        expQ.push_back(sampleValid ? {sampleData, 8'h00} : 32'h0);
        if (sampleValid) takePending = 1; else urExp = 1;
      end
    end
  end

  // monitor: samples data on logical bit clock rise, pops and compares
  always @(negedge clk) begin
    bit curB;
    int p;
    bit expLr;
    logic [31:0] e;
    curB = monMaster ? (bclkOut ^ clkInv[2]) : extLogical;
    if (armed && !prevB && curB) begin
      p = monK % frameLen;
      if (monMaster) begin
        expLr = isI2s ? (p >= 32) : (p == 0);
        check((lrclkOut ^ clkInv[3]) == expLr, {"R5 R8 frame clock ", curTag},
              32'(lrclkOut), 32'(expLr));
        if (monK == 1)
          check((cyc - lastRise) == 2 * (int'(clkDiv) + 1), "R6 bit clock period",
                32'(cyc - lastRise), 32'(2 * (int'(clkDiv) + 1)));
        lastRise = cyc;
      end
      if (monK >= dly) begin
        word = {word[30:0], sdata};
        if ((monK - dly) % 32 == 31) begin
          if (expQ.size() == 0) check(0, {"R9 no slot queued ", curTag}, word, 0);
          else begin
            e = expQ.pop_front();
            check(word === e, {"R3 R4 slot word ", curTag}, word, e);
          end
        end
      end
      monK++;
    end
    prevB = curB;
  end

  task automatic driveExt(int nBits, int L, logic [3:0] inv);
    repeat (4) @(posedge clk);
    for (int b = 0; b < nBits; b++) begin
      @(posedge clk); #5;
      extLogical = 0; extBclk = inv[0]; extLrclk = ((b % L) == 0) ^ inv[1];
      repeat (4) @(posedge clk); #5;
      extLogical = 1; extBclk = ~inv[0];
      repeat (3) @(posedge clk);
    end
    repeat (6) @(posedge clk);
  endtask

  task automatic runTest(string tag, logic [2:0] code, logic [2:0] chm1, logic [7:0] div,
                         logic [3:0] inv, bit mst, bit valid, int nBits);
    int chans;
    bit b0, l0;
    chans = (code <= 1) ? 1 : (code <= 3) ? 2 : int'(chm1) + 1;
    @(negedge clk);
    curTag = tag;
    fmtCode = code; tdmChans = chm1; clkDiv = div; clkInv = inv;
    masterMode = mst; sampleValid = valid;
    extLogical = 1; extBclk = ~inv[0]; extLrclk = inv[1];
    frameLen = 32 * chans; dly = (code == 1 || code == 3 || code == 5) ? 1 : 0;
    isI2s = (code == 3); monMaster = mst;
    expQ.delete(); expQ.push_back(32'h0);
    monK = 0; word = '0; prevB = 1;
    repeat (2) @(negedge clk);
    armed = 1; enable = 1;
    if (mst) wait (monK >= nBits);
    else driveExt(nBits, frameLen, inv);
    @(negedge clk);
    enable = 0; armed = 0;
    repeat (3) @(negedge clk);
    b0 = bclkOut; l0 = lrclkOut;
    repeat (40) @(negedge clk);
    check(sdata == 0 && bclkOut == b0 && lrclkOut == l0, {"R11 idle outputs static ", tag},
          {29'd0, sdata, bclkOut, lrclkOut}, {29'd0, 1'b0, b0, l0});
    expQ.delete();
  endtask

  initial begin
    rstN = 0; enable = 0; masterMode = 1; fmtCode = 0; tdmChans = 0; clkInv = 0;
    clkDiv = 1; sampleValid = 1; extBclk = 1; extLrclk = 0;
    repeat (3) @(negedge clk);
    // R11 R6 reset state: data low, no request, bit clock resting high
    check(sdata == 0 && sampleReq == 0 && underrun == 0 && bclkOut == 1,
          "R11 R6 reset state", {28'd0, sdata, sampleReq, underrun, bclkOut}, 32'h1);
    rstN = 1;
    repeat (3) @(negedge clk);

    runTest("R1 mono",                       3'd0, 3'd0, 8'd1, 4'b0000, 1, 1, 32 * 10);
    runTest("R5 R8 I2S inverted master",     3'd3, 3'd0, 8'd2, 4'b1100, 1, 1, 64 * 4);
    runTest("R2 TDM eight channels",         3'd4, 3'd7, 8'd1, 4'b0000, 1, 1, 256 * 2);
    runTest("R6 PCM fastest divider",        3'd2, 3'd0, 8'd0, 4'b0000, 1, 1, 64 * 4);
    runTest("R10 mono delayed starved",      3'd1, 3'd0, 8'd1, 4'b0100, 1, 0, 32 * 6);
    runTest("R7 R8 slave TDM delayed",       3'd5, 3'd3, 8'd0, 4'b0011, 0, 1, 128 * 3);

    // R1 reserved code keeps the block idle although enabled
    @(negedge clk);
    masterMode = 1; clkInv = 0; fmtCode = 3'd6; enable = 1;
    begin
      bit b0;
      repeat (2) @(negedge clk);
      b0 = bclkOut;
      repeat (200) @(negedge clk);
      check(sdata == 0 && bclkOut == b0, "R1 reserved code idle",
            {30'd0, sdata, bclkOut}, {30'd0, 1'b0, b0});
    end
    enable = 0;
    repeat (5) @(negedge clk);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule